// File: doc/BRIEF.md
# SDRAM Refresh and Precharge Sequencer

This block sits in front of a four-bank synchronous DRAM and decides which command may go to the device in each cycle. The controller offers one request at a time (open a row, read, write, read or write with automatic close, close one bank, close every bank, enter or leave self refresh). The sequencer accepts it only when the bank timing allows it, and then drives the command code, bank number and auto-close flag from a register one cycle after acceptance. A per-bank tracker knows whether each bank is idle, open, waiting to close itself after an auto-close burst, or recharging. All delays are parameters in clock cycles; a delay given in nanoseconds is divided by the clock period and rounded up before it is set.

Refresh is driven by a periodic `tick`, one pulse per refresh interval (the 64 ms window divided by 4096 rows). Each pulse adds to a saturating due count. A nonzero count blocks new requests. The sequencer then lets running bursts and write recovery finish, closes all open banks, issues an auto refresh, and holds off for the row-cycle time. After self refresh ends, a full burst of refreshes is forced before normal service resumes.

The sequencer states are SERVE (accept requests), DRAIN (wait for bursts, recovery and recharge to end), RPWAIT (wait the recharge time after the close-all), RCWAIT (wait the row-cycle time after a refresh), SELF (device in self refresh) and SRXWAIT (refresh burst after self-refresh exit). The transitions are: SERVE to DRAIN when refresh is due; SERVE to SELF on an accepted self-refresh entry; DRAIN to RPWAIT when a close-all is issued; DRAIN to RCWAIT when a refresh is issued directly; RPWAIT to RCWAIT when a refresh is issued; RCWAIT to SERVE when its timer ends; SELF to SRXWAIT on an accepted exit; SRXWAIT to SERVE after the last burst refresh and its row-cycle wait. Each bank moves IDLE to OPEN on activate, OPEN to PRECH on a close, OPEN to APWAIT on an auto-close column command, APWAIT to PRECH when recovery ends, PRECH to IDLE when the recharge time ends, and PRECH to OPEN on an activate issued in its final recharge cycle.

Top module: `sdram_refresh_sequencer`

## Requirements
- R1: After reset `cmd` is 0 (no operation), no bank is open or busy, `maint_busy` is low and an activate request (`req_op`=0) to any bank shows `req_ready` high.
- R2: An activate to an idle bank is accepted, and the next cycle shows `cmd`=1 with that bank on `cmd_bank` and its `bank_open` bit set. An activate to an open bank is refused.
- R3: A read (`req_op`=1, `cmd`=2) or write (`req_op`=2, `cmd`=3) goes only to an open bank. A further column command to the same bank is accepted no earlier than BL cycles after the previous one.
- R4: A close of one bank (`req_op`=3, `cmd`=4) is accepted no earlier than BL+T_RDL-1 cycles after a write to that bank, and no earlier than BL cycles after a read.
- R5: A single-bank close affects only the bank on `req_bank`. A close-all (`req_op`=4, `cmd`=5) closes every open bank. A closed bank accepts an activate T_RP cycles after the close.
- R6: A column command with `req_ap`=1 sets `cmd_ap`. From then the bank shows `bank_busy` and refuses every request until it has closed itself. An activate is next accepted BL+T_RDL-1+T_RP cycles after an auto-close write, and BL+T_RP cycles after an auto-close read.
- R7: Each `tick` adds one to a due count that saturates at DUE_MAX. While the count is nonzero no request is accepted and `maint_busy` is high.
- R8: A due refresh waits for running bursts and write recovery. It then issues a close-all if any bank is open, and issues the refresh (`cmd`=6) T_RP cycles later, or two cycles after the tick if all banks were already closed. Each refresh consumes one due count, and an activate is accepted no earlier than T_RC+1 cycles after a refresh.
- R9: A refresh is issued only while every bank is closed, and never cuts short the write-recovery time of a bank.
- R10: Self-refresh entry (`req_op`=5, `cmd`=7) is accepted only when every bank is idle. In self refresh only the exit request (`req_op`=6, `cmd`=8) is accepted, and ticks have no effect.
- R11: After self-refresh exit the sequencer issues XBURST refreshes spaced T_RC cycles apart, the first T_RC cycles after the exit command, and accepts an activate T_RC+1 cycles after the last one, with the due count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per refresh interval |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request kind: 0 activate, 1 read, 2 write, 3 close bank, 4 close all, 5 self-refresh entry, 6 self-refresh exit |
| req_bank | input | BW | Target bank of the request |
| req_ap | input | 1 | Auto-close after a read or write |
| req_ready | output | 1 | The request on the inputs would be accepted at the next edge |
| cmd | output | 4 | Issued command: 0 none, 1 activate, 2 read, 3 write, 4 close, 5 close all, 6 refresh, 7 self-refresh entry, 8 self-refresh exit |
| cmd_bank | output | BW | Bank of the issued command |
| cmd_ap | output | 1 | Auto-close flag of the issued column command |
| bank_open | output | BANKS | Bank has an open row |
| bank_busy | output | BANKS | Bank is closing itself or recharging |
| maint_busy | output | 1 | Refresh or self-refresh handling in progress |

## Verification
`req_ready` is combinational and is sampled in the same cycle the request is driven. The command it grants appears on `cmd` after the following edge. Each bench task therefore drives a request just after an edge and reads `req_ready` before the next one. It counts edges until acceptance and compares that count with the delay the requirement gives: BL for column spacing, BL+T_RDL-1 for write-to-close, T_RP for close-to-activate, T_RC+1 for refresh-to-activate. Refresh timing is counted from the tick edge, because the due count, the DRAIN state and the command register each add one cycle. The exit burst is checked by counting refresh commands cycle by cycle, from the exit command until the first activate is accepted.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_SRE  = 3'd5,
        OP_SRX  = 3'd6
    } op_e;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,
        C_ACT  = 4'd1,
        C_RD   = 4'd2,
        C_WR   = 4'd3,
        C_PRE  = 4'd4,
        C_PREA = 4'd5,
        C_REF  = 4'd6,
        C_SRE  = 4'd7,
        C_SRX  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        B_IDLE,
        B_OPEN,
        B_APWAIT,
        B_PRECH
    } bank_st_e;

    typedef enum logic [2:0] {
        S_SERVE,
        S_DRAIN,
        S_RPWAIT,
        S_RCWAIT,
        S_SELF,
        S_SRXWAIT
    } seq_st_e;

endpackage

// File: rtl/sdseq_bank.sv
module sdseq_bank
    import sdseq_pkg::*;
#(
    parameter int BL    = 4,
    parameter int T_RDL = 2,
    parameter int T_RP  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic col_i,
    input  logic col_wr_i,
    input  logic col_ap_i,
    input  logic pre_i,
    output logic open_o,
    output logic busy_o,
    output logic can_act_o,
    output logic can_col_o,
    output logic can_pre_o,
    output logic quiet_o
);
    localparam int CW = $clog2(BL + T_RDL + T_RP + 2);

    bank_st_e        st;
    logic [CW-1:0]   col_cnt;
    logic [CW-1:0]   pre_cnt;
    logic [CW-1:0]   rp_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= B_IDLE;
            col_cnt <= '0;
            pre_cnt <= '0;
            rp_cnt  <= '0;
        end else begin
            if (col_i) begin
                col_cnt <= CW'(BL - 1);
                pre_cnt <= col_wr_i ? CW'(BL + T_RDL - 2) : CW'(BL - 1);
            end else begin
                if (col_cnt != '0) col_cnt <= col_cnt - 1'b1;
                if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
            end
            if (rp_cnt != '0) rp_cnt <= rp_cnt - 1'b1;
            unique case (st)
                B_IDLE: if (act_i) st <= B_OPEN;
                B_OPEN: begin
                    if (col_i && col_ap_i) begin
                        st <= B_APWAIT;
                    end else if (pre_i) begin
                        st     <= B_PRECH;
                        rp_cnt <= CW'(T_RP - 1);
                    end
                end
                B_APWAIT: begin
                    if (pre_cnt == '0) begin
                        st     <= B_PRECH;
                        rp_cnt <= CW'(T_RP - 1);
                    end
                end
                B_PRECH: begin
                    if (act_i)              st <= B_OPEN;
                    else if (rp_cnt == '0)  st <= B_IDLE;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        open_o    = (st == B_OPEN);
        busy_o    = (st == B_APWAIT) || (st == B_PRECH);
        can_act_o = (st == B_IDLE) || (st == B_PRECH && rp_cnt == '0);
        can_col_o = (st == B_OPEN) && (col_cnt == '0);
        can_pre_o = (st != B_APWAIT) && (pre_cnt == '0);
        quiet_o   = can_act_o || ((st == B_OPEN) && (pre_cnt == '0));
    end

    // R3
    col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_i |-> (st == B_OPEN && col_cnt == '0));

    // R4
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && st == B_OPEN) |-> (pre_cnt == '0));

    // R6
    ap_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_APWAIT) |-> (!col_i && !act_i));

endmodule

// File: rtl/sdseq_refcnt.sv
module sdseq_refcnt #(
    parameter int DUE_MAX = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         dec_i,
    input  logic                         clr_i,
    output logic [$clog2(DUE_MAX+1)-1:0] due_o
);
    localparam int DW = $clog2(DUE_MAX + 1);

    logic [DW-1:0] due_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            due_q <= '0;
        end else if (tick_i && !dec_i) begin
            if (due_q != DW'(DUE_MAX)) due_q <= due_q + 1'b1;
        end else if (dec_i && !tick_i) begin
            if (due_q != '0) due_q <= due_q - 1'b1;
        end
    end

    assign due_o = due_q;

    // R7
    due_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        due_q <= DW'(DUE_MAX));

    // R8
    dec_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (due_q != '0));

endmodule

// File: rtl/sdram_refresh_sequencer.sv
module sdram_refresh_sequencer
    import sdseq_pkg::*;
#(
    parameter int BANKS   = 4,
    parameter int BW      = $clog2(BANKS),
    parameter int BL      = 4,
    parameter int T_RDL   = 2,
    parameter int T_RP    = 3,
    parameter int T_RC    = 9,
    parameter int DUE_MAX = 8,
    parameter int XBURST  = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [BW-1:0]    req_bank,
    input  logic             req_ap,
    output logic             req_ready,
    output logic [3:0]       cmd,
    output logic [BW-1:0]    cmd_bank,
    output logic             cmd_ap,
    output logic [BANKS-1:0] bank_open,
    output logic [BANKS-1:0] bank_busy,
    output logic             maint_busy
);
    localparam int WW = $clog2(T_RC + T_RP + 1) + 1;
    localparam int XW = $clog2(XBURST + 1);
    localparam int DW = $clog2(DUE_MAX + 1);

    op_e              op;
    seq_st_e          st, st_nx;
    logic [WW-1:0]    wcnt, w_val;
    logic [XW-1:0]    xleft;
    logic [DW-1:0]    due;
    logic             w_load, x_load, x_dec, ref_dec, ref_clr;
    logic             acc_ok, accept;
    cmd_e             nx_cmd, cmd_q;
    logic [BW-1:0]    nx_bank, bank_q;
    logic             nx_ap, ap_q;
    logic [BANKS-1:0] sel, act_v, col_v, pre_v;
    logic             col_wr, col_ap, prea;
    logic [BANKS-1:0] open_v, busy_v, can_act_v, can_col_v, can_pre_v, quiet_v;

    assign op  = op_e'(req_op);
    assign sel = BANKS'(1) << req_bank;

    genvar gi;
    generate
        for (gi = 0; gi < BANKS; gi++) begin : g_bank
            sdseq_bank #(.BL(BL), .T_RDL(T_RDL), .T_RP(T_RP)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .act_i     (act_v[gi]),
                .col_i     (col_v[gi]),
                .col_wr_i  (col_wr),
                .col_ap_i  (col_ap),
                .pre_i     (pre_v[gi] | prea),
                .open_o    (open_v[gi]),
                .busy_o    (busy_v[gi]),
                .can_act_o (can_act_v[gi]),
                .can_col_o (can_col_v[gi]),
                .can_pre_o (can_pre_v[gi]),
                .quiet_o   (quiet_v[gi])
            );
        end
    endgenerate

    sdseq_refcnt #(.DUE_MAX(DUE_MAX)) u_refcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .dec_i  (ref_dec),
        .clr_i  (ref_clr),
        .due_o  (due)
    );

    // Acceptance rule
    always_comb begin
        acc_ok = 1'b0;
        unique case (st)
            S_SERVE: begin
                if (due == '0) begin
                    unique case (op)
                        OP_ACT:        acc_ok = can_act_v[req_bank];
                        OP_RD, OP_WR:  acc_ok = can_col_v[req_bank];
                        OP_PRE:        acc_ok = can_pre_v[req_bank];
                        OP_PREA:       acc_ok = &can_pre_v;
                        OP_SRE:        acc_ok = &can_act_v;
                        default:       acc_ok = 1'b0;
                    endcase
                end
            end
            S_SELF:  acc_ok = (op == OP_SRX);
            default: acc_ok = 1'b0;
        endcase
    end

    assign req_ready = acc_ok;
    assign accept    = req_valid && acc_ok;

    // Next state and command selection
    always_comb begin
        st_nx   = st;
        nx_cmd  = C_NOP;
        nx_bank = '0;
        nx_ap   = 1'b0;
        w_load  = 1'b0;
        w_val   = '0;
        x_load  = 1'b0;
        x_dec   = 1'b0;
        ref_dec = 1'b0;
        ref_clr = 1'b0;
        act_v   = '0;
        col_v   = '0;
        pre_v   = '0;
        col_wr  = 1'b0;
        col_ap  = 1'b0;
        prea    = 1'b0;
        unique case (st)
            S_SERVE: begin
                if (due != '0) begin
                    st_nx = S_DRAIN;
                end else if (accept) begin
                    nx_bank = req_bank;
                    unique case (op)
                        OP_ACT: begin
                            nx_cmd = C_ACT;
                            act_v  = sel;
                        end
                        OP_RD, OP_WR: begin
                            nx_cmd = (op == OP_WR) ? C_WR : C_RD;
                            nx_ap  = req_ap;
                            col_v  = sel;
                            col_wr = (op == OP_WR);
                            col_ap = req_ap;
                        end
                        OP_PRE: begin
                            nx_cmd = C_PRE;
                            pre_v  = sel;
                        end
                        OP_PREA: begin
                            nx_cmd  = C_PREA;
                            nx_bank = '0;
                            prea    = 1'b1;
                        end
                        OP_SRE: begin
                            nx_cmd  = C_SRE;
                            nx_bank = '0;
                            st_nx   = S_SELF;
                        end
                        default: nx_cmd = C_NOP;
                    endcase
                end
            end
            S_DRAIN: begin
                if (&quiet_v) begin
                    if (|open_v) begin
                        nx_cmd = C_PREA;
                        prea   = 1'b1;
                        w_load = 1'b1;
                        w_val  = WW'(T_RP - 1);
                        st_nx  = S_RPWAIT;
                    end else begin
                        nx_cmd  = C_REF;
                        ref_dec = 1'b1;
                        w_load  = 1'b1;
                        w_val   = WW'(T_RC - 1);
                        st_nx   = S_RCWAIT;
                    end
                end
            end
            S_RPWAIT: begin
                if (wcnt == '0) begin
                    nx_cmd  = C_REF;
                    ref_dec = 1'b1;
                    w_load  = 1'b1;
                    w_val   = WW'(T_RC - 1);
                    st_nx   = S_RCWAIT;
                end
            end
            S_RCWAIT: begin
                if (wcnt == '0) st_nx = S_SERVE;
            end
            S_SELF: begin
                ref_clr = 1'b1;
                if (accept) begin
                    nx_cmd = C_SRX;
                    w_load = 1'b1;
                    w_val  = WW'(T_RC - 1);
                    x_load = 1'b1;
                    st_nx  = S_SRXWAIT;
                end
            end
            S_SRXWAIT: begin
                ref_clr = 1'b1;
                if (wcnt == '0) begin
                    if (xleft == '0) begin
                        st_nx = S_SERVE;
                    end else begin
                        nx_cmd = C_REF;
                        x_dec  = 1'b1;
                        w_load = 1'b1;
                        w_val  = WW'(T_RC - 1);
                    end
                end
            end
            default: st_nx = S_SERVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_SERVE;
            wcnt  <= '0;
            xleft <= '0;
        end else begin
            st <= st_nx;
            if (w_load)           wcnt <= w_val;
            else if (wcnt != '0)  wcnt <= wcnt - 1'b1;
            if (x_load)           xleft <= XW'(XBURST);
            else if (x_dec)       xleft <= xleft - 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= C_NOP;
            bank_q <= '0;
            ap_q   <= 1'b0;
        end else begin
            cmd_q  <= nx_cmd;
            bank_q <= nx_bank;
            ap_q   <= nx_ap;
        end
    end

    assign cmd        = cmd_q;
    assign cmd_bank   = bank_q;
    assign cmd_ap     = ap_q;
    assign bank_open  = open_v;
    assign bank_busy  = busy_v;
    assign maint_busy = (st != S_SERVE) || (due != '0);

    // Cycles since the last refresh command, for the row-cycle check
    logic [WW-1:0] since_ref;
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_ref <= WW'(T_RC);
        else if (cmd_q == C_REF)            since_ref <= WW'(1);
        else if (since_ref < WW'(T_RC))     since_ref <= since_ref + 1'b1;
    end

    // R9
    ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_REF) |-> (bank_open == '0));

    // R8
    ref_rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_ACT) |-> (since_ref >= WW'(T_RC)));

    // R10
    sre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == C_SRE) |-> (bank_open == '0 && bank_busy == '0));

    // R7
    due_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SERVE && due != '0) |=> (cmd_q == C_NOP));

endmodule

// File: tb/tb_sdram_refresh_sequencer.sv
module tb_sdram_refresh_sequencer;
    localparam int BL = 4, T_RDL = 2, T_RP = 3, T_RC = 9, DUE_MAX = 8, XBURST = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic       req_ap = 1'b0;
    logic       req_ready;
    logic [3:0] cmd;
    logic [1:0] cmd_bank;
    logic       cmd_ap;
    logic [3:0] bank_open, bank_busy;
    logic       maint_busy;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sdram_refresh_sequencer #(.BL(BL), .T_RDL(T_RDL), .T_RP(T_RP), .T_RC(T_RC),
                              .DUE_MAX(DUE_MAX), .XBURST(XBURST)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
        .req_op(req_op), .req_bank(req_bank), .req_ap(req_ap),
        .req_ready(req_ready), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
        .bank_open(bank_open), .bank_busy(bank_busy), .maint_busy(maint_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Drive a request until accepted; gap = edges from the previous return
    task automatic send(input int op, input int b, input bit ap, output int gap);
        bit ok;
        gap = 0;
        req_op = 3'(op); req_bank = 2'(b); req_ap = ap; req_valid = 1'b1;
        forever begin
            #1;
            ok = req_ready;
            @(posedge clk);
            #1;
            gap++;
            if (ok || gap > 200) break;
        end
        req_valid = 1'b0; req_ap = 1'b0;
    endtask

    task automatic probe(input int op, input int b, output bit r);
        req_op = 3'(op); req_bank = 2'(b); req_valid = 1'b0;
        #1;
        r = req_ready;
    endtask

    task automatic wait_cmd(input int code, output int gap);
        gap = 0;
        do begin
            @(posedge clk);
            #1;
            gap++;
        end while (cmd != 4'(code) && gap < 300);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic t_reset();
        bit r;
        chk("R1 cmd", cmd, 0);
        chk("R1 open", bank_open, 0);
        chk("R1 busy", bank_busy, 0);
        chk("R1 maint", maint_busy, 0);
        probe(0, 3, r);
        chk("R1 ready", r, 1);
    endtask

    task automatic t_act_col();
        int g; bit r;
        send(0, 1, 0, g);
        chk("R2 gap", g, 1);
        chk("R2 cmd", cmd, 1);
        chk("R2 bank", cmd_bank, 1);
        chk("R2 open", bank_open, 4'b0010);
        probe(0, 1, r);
        chk("R2 reopen refused", r, 0);
        send(1, 1, 0, g);
        chk("R3 rd cmd", cmd, 2);
        send(1, 1, 0, g);
        chk("R3 rd-rd gap", g, BL);
        send(2, 1, 0, g);
        chk("R3 rd-wr gap", g, BL);
        chk("R3 wr cmd", cmd, 3);
        send(3, 1, 0, g);
        chk("R4 wr-pre gap", g, BL + T_RDL - 1);
        chk("R4 pre cmd", cmd, 4);
        send(0, 1, 0, g);
        chk("R5 pre-act gap", g, T_RP);
        send(1, 1, 0, g);
        send(3, 1, 0, g);
        chk("R4 rd-pre gap", g, BL);
        step(4);
    endtask

    task automatic t_autopre();
        int g; bit r;
        send(0, 2, 0, g);
        send(2, 2, 1, g);
        chk("R6 wr cmd", cmd, 3);
        chk("R6 ap flag", cmd_ap, 1);
        chk("R6 busy", bank_busy[2], 1);
        probe(1, 2, r);
        chk("R6 rd refused", r, 0);
        send(0, 2, 0, g);
        chk("R6 wrap-act gap", g, BL + T_RDL - 1 + T_RP);
        send(1, 2, 1, g);
        send(0, 2, 0, g);
        chk("R6 rdap-act gap", g, BL + T_RP);
    endtask

    task automatic t_prea();
        int g;
        send(0, 0, 0, g);
        send(0, 1, 0, g);
        chk("R5 open set", bank_open, 4'b0111);
        send(4, 0, 0, g);
        chk("R5 prea cmd", cmd, 5);
        chk("R5 prea closed", bank_open, 0);
        send(0, 3, 0, g);
        send(0, 0, 0, g);
        send(3, 3, 0, g);
        chk("R5 single close", bank_open, 4'b0001);
        send(4, 0, 0, g);
        step(5);
    endtask

    task automatic t_refresh_idle();
        int g; bit r;
        pulse_tick();
        probe(0, 0, r);
        chk("R7 blocked", r, 0);
        chk("R7 maint", maint_busy, 1);
        wait_cmd(6, g);
        chk("R8 ref gap", g, 2);
        chk("R9 closed", bank_open, 0);
        send(0, 0, 0, g);
        chk("R8 ref-act gap", g, T_RC + 1);
    endtask

    task automatic t_refresh_write();
        int g;
        send(2, 0, 0, g);
        pulse_tick();
        wait_cmd(5, g);
        chk("R9 recovery kept", g, BL + T_RDL - 2);
        wait_cmd(6, g);
        chk("R8 prea-ref gap", g, T_RP);
        chk("R9 closed at ref", bank_open, 0);
        step(T_RC + 2);
    endtask

    task automatic t_saturate();
        int n = 0; int guard = 0;
        tick = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            #1;
            if (cmd == 4'd6) n++;
        end
        tick = 1'b0;
        while (maint_busy && guard < 300) begin
            @(posedge clk);
            #1;
            guard++;
            if (cmd == 4'd6) n++;
        end
        chk("R7 saturated refs", n, DUE_MAX + 1);
    endtask

    task automatic t_self();
        int g; int nref = 0; int first = 0; bit r; bit ok;
        send(0, 1, 0, g);
        probe(5, 0, r);
        chk("R10 sre refused open", r, 0);
        send(3, 1, 0, g);
        send(5, 0, 0, g);
        chk("R10 sre gap", g, T_RP);
        chk("R10 sre cmd", cmd, 7);
        probe(0, 0, r);
        chk("R10 act refused", r, 0);
        pulse_tick();
        pulse_tick();
        send(6, 0, 0, g);
        chk("R10 srx cmd", cmd, 8);
        req_op = 3'd0; req_bank = 2'd0; req_valid = 1'b1;
        g = 0;
        forever begin
            #1;
            ok = req_ready;
            @(posedge clk);
            #1;
            g++;
            if (cmd == 4'd6) begin
                nref++;
                if (nref == 1) first = g;
            end
            if (ok || g > 40000) break;
        end
        req_valid = 1'b0;
        chk("R11 first ref", first, T_RC);
        chk("R11 ref count", nref, XBURST);
        chk("R11 act gap", g, T_RC * (XBURST + 1) + 1);
        chk("R11 act cmd", cmd, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_act_col();
        t_autopre();
        t_prea();
        t_refresh_idle();
        t_refresh_write();
        t_saturate();
        t_self();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule